// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Channel

This block is one output channel of a multi-channel timer array, used as a pulse-width modulator. It compares the low byte of a shared free-running timebase with its own active threshold byte. The output pin is low while the timebase byte is below the threshold and high from the threshold up to the end of the period. Every channel sees the same timebase, so all channels run at one PWM frequency: the timebase tick rate divided by 256.

Software writes a new duty value into a shadow byte at any time. The channel copies the shadow byte into the active threshold only when the timebase low byte wraps from 255 to 0. A duty change therefore never cuts a period short or stretches it. The timebase and its clock-source choice lie outside the block. The channel reacts only to the tick strobe, so it works with any source and any tick rate. For a wanted high fraction D, software writes 256 × (1 − D), truncated to 8 bits.

Top module: `pwm_slice`

## Requirements
- R1: While reset is active, and after it until the mode is enabled, the pin is low. Reset clears the mode bits and sets both the shadow and the active byte to 0, so enabling the mode after reset with no wrap drives the pin high at every count.
- R2: The mode register takes `mode_wdata` on a `mode_we` cycle. Bit 1 is the PWM enable and bit 0 is the compare enable. Unless both bits are 1, the pin is low.
- R3: With the mode enabled, the pin is low while `base_lo` is below the active byte and high while it is greater than or equal to it.
- R4: A write to the shadow byte (`duty_we`) leaves the active byte unchanged until the next wrap.
- R5: A wrap is a cycle in which `base_tick` is 1 and `base_lo` is 255. On that clock edge the active byte takes the shadow value, so the new threshold applies from count 0 onward.
- R6: If `base_lo` is 255 without `base_tick`, or `base_tick` comes at any other count, no transfer takes place.
- R7: An active byte of 0 keeps the pin high at all counts. An active byte of 255 makes the pin high only at count 255.
- R8: If a duty write and a wrap happen in the same cycle, the active byte takes the shadow value from before the write. The written value takes effect at the following wrap.
- R9: Shadow writes and wraps take effect while the mode is disabled, so the transferred value applies as soon as the mode is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_wdata | input | 2 | Mode bits: [1] PWM enable, [0] compare enable |
| duty_we | input | 1 | Write strobe for the shadow duty byte |
| duty_wdata | input | DW | Shadow duty value |
| base_lo | input | DW | Shared timebase low byte |
| base_tick | input | 1 | Timebase advance strobe for this cycle |
| pin_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a duty write that lands in the same clock as a wrap. The old and new shadow values then compete for the active byte. The bench acts as the timebase itself. It raises the tick with `base_lo` at 255 in the same cycle as `duty_we`. It then holds the tick low and sweeps `base_lo` to read the active threshold back through the pin, before and after one more wrap.

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_wdata,
  input  logic          duty_we,
  input  logic [DW-1:0] duty_wdata,
  input  logic [DW-1:0] base_lo,
  input  logic          base_tick,
  output logic          pin_out
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [1:0]    mode_q;
  logic [DW-1:0] shadow_q;
  logic [DW-1:0] active_q;
  logic          run;
  logic          wrap;

  assign run  = &mode_q;
  assign wrap = base_tick && (base_lo == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (duty_we) shadow_q <= duty_wdata;
      if (wrap)    active_q <= shadow_q;
    end
  end

  assign pin_out = run && (base_lo >= active_q);
endmodule

module pwm_slice_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_we,
  input logic [1:0]    mode_wdata,
  input logic          run,
  input logic [DW-1:0] base_lo,
  input logic          base_tick,
  input logic [DW-1:0] shadow,
  input logic [DW-1:0] active,
  input logic          pin_out
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !pin_out);

  a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_we && mode_wdata != 2'b11) |-> !pin_out);

  a_r3_below_low: assert property (@(posedge clk) disable iff (!rst_n)
    (base_lo < active) |-> !pin_out);

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(base_tick && base_lo == {DW{1'b1}}) |-> active == $past(shadow));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(base_tick && base_lo == {DW{1'b1}}) |-> $stable(active));

  a_r7_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active == '0) |-> pin_out);
endmodule

bind pwm_slice pwm_slice_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .run(run), .base_lo(base_lo), .base_tick(base_tick),
  .shadow(shadow_q), .active(active_q), .pin_out(pin_out)
);

// File: tb/tb_pwm_slice.sv
`timescale 1ns/1ps
module tb_pwm_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic       duty_we = 1'b0;
  logic [7:0] duty_wdata = '0;
  logic [7:0] base_lo = '0;
  logic       base_tick = 1'b0;
  logic       pin_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_slice #(.DW(8)) dut (.*);

  // {mode, duty, probe count, expected pin}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {2'b11, 8'h80, 8'h7F, 1'b0},
    {2'b11, 8'h80, 8'h80, 1'b1},
    {2'b11, 8'h40, 8'hC0, 1'b1},
    {2'b11, 8'h40, 8'h3F, 1'b0},
    {2'b01, 8'h10, 8'h20, 1'b0},
    {2'b10, 8'h10, 8'h20, 1'b0},
    {2'b11, 8'h00, 8'h00, 1'b1},
    {2'b11, 8'hFF, 8'hFE, 1'b0},
    {2'b11, 8'hFF, 8'hFF, 1'b1},
    {2'b11, 8'h01, 8'h00, 1'b0}
  };

  task automatic check(input logic exp, input string rq);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s: pin_out=%b expected %b (base_lo=%02h)", rq, pin_out, exp, base_lo);
    end
  endtask

  task automatic probe(input logic [7:0] lo, input logic exp, input string rq);
    base_lo = lo;
    #1;
    check(exp, rq);
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_duty(input logic [7:0] d);
    @(negedge clk); duty_we = 1'b1; duty_wdata = d;
    @(negedge clk); duty_we = 1'b0;
  endtask

  task automatic wrap();
    @(negedge clk); base_lo = 8'hFF; base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0; base_lo = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    probe(8'hFF, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    probe(8'hFF, 1'b0, "R1 mode off after reset");
    wr_mode(2'b11);
    probe(8'h00, 1'b1, "R1 active zero after reset");

    for (int i = 0; i < NV; i++) begin
      wr_mode(VEC[i][18:17]);
      wr_duty(VEC[i][16:9]);
      wrap();
      probe(VEC[i][8:1], VEC[i][0], VEC[i][18:17] == 2'b11 ? "R3/R7 vector" : "R2 vector");
    end

    // active is 0x01 now
    wr_duty(8'hF0);
    probe(8'h10, 1'b1, "R4 shadow not yet active");
    @(negedge clk); base_lo = 8'hFF; base_tick = 1'b0;
    @(negedge clk); base_lo = 8'h80; base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0;
    probe(8'h10, 1'b1, "R6 no wrap without tick at 255");
    wrap();
    probe(8'h10, 1'b0, "R5 new threshold after wrap");
    probe(8'hF0, 1'b1, "R5 at new threshold");

    // write and wrap in the same cycle
    @(negedge clk); base_lo = 8'hFF; base_tick = 1'b1; duty_we = 1'b1; duty_wdata = 8'h20;
    @(negedge clk); base_tick = 1'b0; duty_we = 1'b0;
    probe(8'h30, 1'b0, "R8 old shadow transferred");
    wrap();
    probe(8'h30, 1'b1, "R8 new value at next wrap");

    wr_mode(2'b00);
    wr_duty(8'h90);
    probe(8'hA0, 1'b0, "R2 disabled");
    wrap();
    wr_mode(2'b11);
    probe(8'h8F, 1'b0, "R9 transfer while disabled");
    probe(8'h90, 1'b1, "R9 transfer while disabled");

    @(negedge clk); rst_n = 1'b0;
    probe(8'hFF, 1'b0, "R1 reset mid-run");
    @(negedge clk); rst_n = 1'b1;
    probe(8'hFF, 1'b0, "R1 mode cleared by reset");
    wr_mode(2'b11);
    probe(8'h00, 1'b1, "R1 active cleared by reset");
    finish_run();
  end
endmodule